// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Array Write Guard

This block sits between a parallel byte bus and a small array of byte storage that stands in for a nonvolatile memory. The chip-enable, output-enable and write-enable strobes arrive already sampled into the clock domain. The block turns them into read and write events. A write counts only if its strobe stays active for a minimum number of clock edges, occurs after a power-on lockout, and passes a software protection check. Each write, accepted or not, starts a timed internal cycle. For the length of that cycle, reads return a status byte whose bit 6 flips on every read.

The protection check is a command recognizer. It watches the stream of write events for fixed address/data sequences. One sequence turns protection on. The same opening sequence, placed just before a byte or page of data, unlocks that one page. A longer sequence turns protection off. The protection flag survives the ordinary reset and the loss of power-good. Only a separate retain-reset input can clear it.

Top module: `eeprom_guard`

## Requirements
- R1: A write is taken when the strobe ends, and only if CE is low, WE is low and OE is high together. A write strobe seen with OE low, or with WE low while CE is high, changes nothing.
- R2: A write strobe held for fewer than MIN_PULSE rising clock edges stores nothing and starts no cycle. A strobe held for exactly MIN_PULSE edges is accepted.
- R3: For LOCK_CYC cycles after pwr_good rises, write strobes are dropped completely. They store nothing and start no timer, so reads keep returning stored data.
- R4: A taken write opens a load window of LOAD_WIN cycles. A later write inside that window joins the same page and restarts the window. The window is followed by a programming phase of TWC_CYC cycles, and writes during that phase are ignored.
- R5: While a load or programming phase runs, each read returns the stored byte with bit 6 replaced by a status bit. That status bit is inverted on every successive read.
- R6: Once the cycle has ended, a read returns the stored byte unchanged, and repeated reads return the same bit 6.
- R7: Writing 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555 sets protection when the cycle that this sequence starts has ended.
- R8: While protected, a write not preceded by the unlock sequence stores nothing but still starts a full cycle, and reads during that cycle return toggling status.
- R9: While protected, bytes written in the load window that directly follows the three-write sequence are stored. The unlock lapses when that cycle ends.
- R10: The six writes 0xAA/0x5555, 0x55/0x2AAA, 0x80/0x5555, 0xAA/0x5555, 0x55/0x2AAA, 0x20/0x5555 clear protection.
- R11: The data bytes of command writes are never stored. Addresses 0x5555 and 0x2AAA can still be written as ordinary locations, provided the write does not match a command step.
- R12: The protection flag is cleared only by retain_rst_n and defaults to off. Lowering rst_n or pwr_good leaves it unchanged.
- R13: A write that does not match the next expected command step aborts the recognizer. That write is then handled as a fresh write: either the first command step or a data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of all volatile state |
| retain_rst_n | input | 1 | Active-low reset of the protection flag only |
| pwr_good | input | 1 | High while supply is good; a rise starts the write lockout |
| ce_n | input | 1 | Chip enable, active low, sampled |
| oe_n | input | 1 | Output enable, active low, sampled |
| we_n | input | 1 | Write enable, active low, sampled |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte, updated one cycle after a read begins |

## Verification
The bench first stores a known byte at each location it probes, so that every blocked write can be caught. A write rejected under protection, during the programming phase, inside the lockout, or because its strobe was too short, would otherwise go unnoticed. Status reads are taken back to back inside a single cycle. A design that failed to flip bit 6, or that started no timer for a rejected write, returns the same bit twice and is caught. Lockout reads are repeated for the opposite reason: a design that ran a timer for a dropped write would flip the bit. The bench also cycles power and rst_n while protection is on, aborts a sequence part-way to confirm that the aborting write is stored, and checks that command bytes never reach the array.

// File: rtl/eeg_pkg.sv
package eeg_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_LOAD,
    CYC_PROG
  } cyc_state_e;

  localparam int unsigned SEQ_LEN = 6;
  localparam logic [14:0] CMD_ADDR_A = 15'h5555;
  localparam logic [14:0] CMD_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  ENA_DATA   = 8'hA0;

  // Address of each step of the long (disable) sequence; the enable
  // sequence shares steps 0 and 1.
  function automatic logic [14:0] seq_addr(input int unsigned idx);
    return (idx == 1 || idx == 4) ? CMD_ADDR_B : CMD_ADDR_A;
  endfunction

  function automatic logic [7:0] seq_data(input int unsigned idx);
    case (idx)
      0, 3:    return 8'hAA;
      1, 4:    return 8'h55;
      2:       return 8'h80;
      5:       return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  // Byte returned while a cycle runs: stored bits with bit 6 replaced.
  function automatic logic [7:0] status_byte(input logic [7:0] stored, input logic tog);
    return {stored[7], tog, stored[5:0]};
  endfunction

endpackage

// File: rtl/eeg_strobe.sv
module eeg_strobe #(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned MIN_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_end,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_start
);
  localparam int unsigned CW = $clog2(MIN_PULSE + 1);

  logic          wr_lvl, rd_lvl, wr_q, rd_q;
  logic [CW-1:0] pw_cnt;

  assign wr_lvl = !ce_n && !we_n && oe_n;
  assign rd_lvl = !ce_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      pw_cnt  <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_q <= wr_lvl;
      rd_q <= rd_lvl;
      if (wr_lvl) begin
        if (pw_cnt != CW'(MIN_PULSE)) pw_cnt <= pw_cnt + 1'b1;
        wr_addr <= addr;
        wr_data <= din;
      end else begin
        pw_cnt <= '0;
      end
    end
  end

  // Event in the cycle after the strobe ends; pw_cnt still holds its width.
  assign wr_end   = wr_q && !wr_lvl && (pw_cnt == CW'(MIN_PULSE));
  assign rd_start = rd_lvl && !rd_q;

endmodule

// File: rtl/eeg_lockout.sv
module eeg_lockout #(
  parameter int unsigned LOCK_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic lock_done
);
  localparam int unsigned LW = $clog2(LOCK_CYC + 1);

  logic [LW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!pwr_good)            cnt <= '0;
    else if (cnt != LW'(LOCK_CYC)) cnt <= cnt + 1'b1;
  end

  assign lock_done = (cnt == LW'(LOCK_CYC));

endmodule

// File: rtl/eeg_cycle.sv
module eeg_cycle
  import eeg_pkg::*;
#(
  parameter int unsigned LOAD_WIN = 7500,
  parameter int unsigned TWC_CYC  = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output cyc_state_e state,
  output logic       busy,
  output logic       prog,
  output logic       done
);
  localparam int unsigned MAXC = (LOAD_WIN > TWC_CYC) ? LOAD_WIN : TWC_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CYC_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        CYC_IDLE: if (start) begin
          state <= CYC_LOAD;
          cnt   <= '0;
        end
        CYC_LOAD: begin
          if (start) begin
            cnt <= '0;
          end else if (cnt == CW'(LOAD_WIN - 1)) begin
            state <= CYC_PROG;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        CYC_PROG: begin
          if (cnt == CW'(TWC_CYC - 1)) begin
            state <= CYC_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= CYC_IDLE;
      endcase
    end
  end

  assign busy = (state != CYC_IDLE);
  assign prog = (state == CYC_PROG);
  assign done = prog && (cnt == CW'(TWC_CYC - 1));

endmodule

// File: rtl/eeg_sdp.sv
module eeg_sdp
  import eeg_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retain_rst_n,
  input  logic              evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              cyc_done,
  output logic              store_en,
  output logic              cyc_start,
  output logic              prot_q,
  output logic              unlk_q
);
  logic [2:0]         idx_q, idx_d;
  logic               arm_q, set_arm, set_unlk, clr_prot, took, ena_hit;
  logic [SEQ_LEN-1:0] hit;

  for (genvar i = 0; i < SEQ_LEN; i++) begin : g_hit
    assign hit[i] = (addr == ADDR_W'(seq_addr(i))) && (data == seq_data(i));
  end

  assign ena_hit = (addr == ADDR_W'(CMD_ADDR_A)) && (data == ENA_DATA);

  always_comb begin
    idx_d     = idx_q;
    store_en  = 1'b0;
    cyc_start = 1'b0;
    set_arm   = 1'b0;
    set_unlk  = 1'b0;
    clr_prot  = 1'b0;
    took      = 1'b0;
    if (evt) begin
      case (idx_q)
        3'd1: if (hit[1]) begin idx_d = 3'd2; took = 1'b1; end
        3'd2: begin
          if (ena_hit) begin
            idx_d     = 3'd0;
            took      = 1'b1;
            cyc_start = 1'b1;
            set_unlk  = 1'b1;
            set_arm   = 1'b1;
          end else if (hit[2]) begin
            idx_d = 3'd3;
            took  = 1'b1;
          end
        end
        3'd3: if (hit[3]) begin idx_d = 3'd4; took = 1'b1; end
        3'd4: if (hit[4]) begin idx_d = 3'd5; took = 1'b1; end
        3'd5: if (hit[5]) begin
          idx_d     = 3'd0;
          took      = 1'b1;
          cyc_start = 1'b1;
          set_unlk  = 1'b1;
          clr_prot  = 1'b1;
        end
        default: ;
      endcase
      // A write that did not advance the recognizer starts afresh.
      if (!took) begin
        if (hit[0]) begin
          idx_d = 3'd1;
        end else begin
          idx_d     = 3'd0;
          cyc_start = 1'b1;
          store_en  = !prot_q || unlk_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      arm_q  <= 1'b0;
      unlk_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      if (clr_prot)      arm_q <= 1'b0;
      else if (set_arm)  arm_q <= 1'b1;
      else if (cyc_done) arm_q <= 1'b0;
      if (set_unlk)      unlk_q <= 1'b1;
      else if (cyc_done) unlk_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge retain_rst_n) begin
    if (!retain_rst_n)           prot_q <= 1'b0;
    else if (clr_prot)           prot_q <= 1'b0;
    else if (cyc_done && arm_q)  prot_q <= 1'b1;
  end

endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
  import eeg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned MEM_AW    = 6,
  parameter int unsigned MIN_PULSE = 2,
  parameter int unsigned LOCK_CYC  = 250000,
  parameter int unsigned LOAD_WIN  = 7500,
  parameter int unsigned TWC_CYC   = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retain_rst_n,
  input  logic              pwr_good,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout
);
  localparam int unsigned MEM_DEPTH = 1 << MEM_AW;

  logic              wr_end, rd_start, lock_done, evt_ok;
  logic              store_en, cyc_start, cyc_done, busy, prog;
  logic              prot_q, unlk_q, tog_q;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data, rd_word, dout_q;
  cyc_state_e        cyc_state;
  logic [7:0]        mem [MEM_DEPTH];

  eeg_strobe #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .wr_end(wr_end), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_start(rd_start)
  );

  eeg_lockout #(.LOCK_CYC(LOCK_CYC)) u_lockout (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .lock_done(lock_done)
  );

  // Writes count only after lockout and never during programming.
  assign evt_ok = wr_end && lock_done && !prog;

  eeg_sdp #(.ADDR_W(ADDR_W)) u_sdp (
    .clk(clk), .rst_n(rst_n), .retain_rst_n(retain_rst_n), .evt(evt_ok),
    .addr(wr_addr), .data(wr_data), .cyc_done(cyc_done),
    .store_en(store_en), .cyc_start(cyc_start), .prot_q(prot_q), .unlk_q(unlk_q)
  );

  eeg_cycle #(.LOAD_WIN(LOAD_WIN), .TWC_CYC(TWC_CYC)) u_cycle (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .state(cyc_state),
    .busy(busy), .prog(prog), .done(cyc_done)
  );

  always_ff @(posedge clk) begin
    if (store_en) mem[wr_addr[MEM_AW-1:0]] <= wr_data;
  end

  assign rd_word = mem[addr[MEM_AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      tog_q  <= 1'b0;
    end else if (rd_start) begin
      if (busy) begin
        dout_q <= status_byte(rd_word, tog_q);
        tog_q  <= ~tog_q;
      end else begin
        dout_q <= rd_word;
      end
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/eeg_checker.sv
module eeg_checker #(
  parameter int unsigned MIN_PULSE = 2,
  parameter int unsigned LOCK_CYC  = 250000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       store_en,
  input logic       cyc_start,
  input logic       prog,
  input logic       busy,
  input logic       prot_q,
  input logic       rd_start,
  input logic [7:0] dout
);
  localparam int unsigned LW = $clog2(LOCK_CYC + 1);
  localparam int unsigned PW = $clog2(MIN_PULSE + 1);

  logic [LW-1:0] ck_lock;
  logic [PW-1:0] ck_w;
  logic          busy_rd_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_lock      <= '0;
      ck_w         <= '0;
      busy_rd_seen <= 1'b0;
    end else begin
      if (!pwr_good)                     ck_lock <= '0;
      else if (ck_lock < LW'(LOCK_CYC))  ck_lock <= ck_lock + 1'b1;
      if (!ce_n && !we_n && oe_n) begin
        if (ck_w < PW'(MIN_PULSE)) ck_w <= ck_w + 1'b1;
      end else begin
        ck_w <= '0;
      end
      if (!busy)         busy_rd_seen <= 1'b0;
      else if (rd_start) busy_rd_seen <= 1'b1;
    end
  end

  p_short_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en || cyc_start) |-> (ck_w >= PW'(MIN_PULSE)));

  p_lockout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en || cyc_start) |-> (ck_lock == LW'(LOCK_CYC)));

  p_prog_ignores_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prog |-> !(store_en || cyc_start));

  p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && busy && busy_rd_seen) |=> (dout[6] != $past(dout[6])));

  p_prot_after_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_q) |-> $past(prog));

  p_prot_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good && !busy) |=> $stable(prot_q));

endmodule

bind eeprom_guard eeg_checker #(.MIN_PULSE(MIN_PULSE), .LOCK_CYC(LOCK_CYC)) u_eeg_checker (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .oe_n(oe_n),
  .we_n(we_n), .store_en(store_en), .cyc_start(cyc_start), .prog(prog),
  .busy(busy), .prot_q(prot_q), .rd_start(rd_start), .dout(dout)
);

// File: tb/test_eeprom_guard.sv
module test_eeprom_guard;
  localparam int unsigned AW    = 15;
  localparam int unsigned MIN_P = 3;
  localparam int unsigned LOCK  = 40;
  localparam int unsigned LOADW = 10;
  localparam int unsigned TWC   = 40;
  localparam int unsigned SETTLE = LOADW + TWC + 6;

  logic          clk = 1'b0;
  logic          rst_n, retain_rst_n, pwr_good, ce_n, oe_n, we_n;
  logic [AW-1:0] addr;
  logic [7:0]    din, dout;

  always #10 clk = ~clk;

  eeprom_guard #(
    .ADDR_W(AW), .MEM_AW(6), .MIN_PULSE(MIN_P), .LOCK_CYC(LOCK),
    .LOAD_WIN(LOADW), .TWC_CYC(TWC)
  ) i_eeprom_guard (.*);

  typedef struct {
    logic [7:0] exp;
    logic [7:0] msk;
    bit         tgl;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  event smp_ev;
  int   n_chk = 0;
  int   n_fail = 0;

  // Monitor: pops one expectation per sampled read.
  initial begin
    exp_t it;
    logic last6;
    last6 = 1'b0;
    forever begin
      @(smp_ev);
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: read sampled with no expected item, got %02h expected none", dout);
      end else begin
        it = sb_q.pop_front();
        if (((dout & it.msk) !== (it.exp & it.msk)) || (it.tgl && dout[6] === last6)) begin
          n_fail++;
          $display("FAIL %s: got %02h expected %02h mask %02h%s", it.tag, dout, it.exp,
                   it.msk, it.tgl ? " with bit6 inverted from previous read" : "");
        end
      end
      last6 = dout[6];
    end
  end

  task automatic wr_raw(input logic [AW-1:0] a, input logic [7:0] d, input int width,
                        input logic c, input logic o);
    addr = a; din = d; ce_n = c; oe_n = o; we_n = 1'b0;
    repeat (width) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_raw(a, d, MIN_P, 1'b0, 1'b1);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] e, input logic [7:0] m,
                        input bit t, input string tag);
    exp_t it;
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    it.exp = e; it.msk = m; it.tgl = t; it.tag = tag;
    sb_q.push_back(it);
    -> smp_ev;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic enable_seq();
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; retain_rst_n = 1'b0; pwr_good = 1'b0;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; retain_rst_n = 1'b1;
    n_chk++;
    if (dout !== 8'h00) begin
      n_fail++;
      $display("FAIL reset R12: got %02h expected 00", dout);
    end
    pwr_good = 1'b1;
    repeat (LOCK + 5) @(negedge clk);

    // R1 R6: plain write, read back after the cycle
    wr(15'h0010, 8'h11); settle();
    rd_chk(15'h0010, 8'h11, 8'hFF, 0, "R1 write taken");
    rd_chk(15'h0010, 8'h11, 8'hFF, 0, "R6 stable after cycle");

    // R5: status reads during the cycle
    wr(15'h0011, 8'h22);
    rd_chk(15'h0011, 8'h22, 8'hBF, 0, "R5 first status read");
    rd_chk(15'h0011, 8'h22, 8'hBF, 1, "R5 second status read");
    rd_chk(15'h0011, 8'h22, 8'hBF, 1, "R5 third status read");
    settle();
    rd_chk(15'h0011, 8'h22, 8'hFF, 0, "R6 data after cycle");
    rd_chk(15'h0011, 8'h22, 8'hFF, 0, "R6 bit6 steady");

    // R4: page of two bytes, then a write during programming
    wr(15'h0018, 8'h31); wr(15'h0019, 8'h32); settle();
    rd_chk(15'h0018, 8'h31, 8'hFF, 0, "R4 page byte 0");
    rd_chk(15'h0019, 8'h32, 8'hFF, 0, "R4 page byte 1");
    wr(15'h001A, 8'h40);
    repeat (LOADW + 2) @(negedge clk);
    wr(15'h001A, 8'h41); settle();
    rd_chk(15'h001A, 8'h40, 8'hFF, 0, "R4 write in programming ignored");

    // R1 inhibits and R2 short pulse
    wr_raw(15'h0010, 8'h99, MIN_P, 1'b0, 1'b0); settle();
    rd_chk(15'h0010, 8'h11, 8'hFF, 0, "R1 OE low inhibits");
    wr_raw(15'h0010, 8'h98, MIN_P, 1'b1, 1'b1); settle();
    rd_chk(15'h0010, 8'h11, 8'hFF, 0, "R1 CE high inhibits");
    wr_raw(15'h0010, 8'h97, MIN_P - 1, 1'b0, 1'b1); settle();
    rd_chk(15'h0010, 8'h11, 8'hFF, 0, "R2 short pulse ignored");

    // R11: command addresses are ordinary locations
    wr(15'h5555, 8'h33); settle();
    wr(15'h2AAA, 8'h44); settle();
    rd_chk(15'h5555, 8'h33, 8'hFF, 0, "R11 write to 5555");
    rd_chk(15'h2AAA, 8'h44, 8'hFF, 0, "R11 write to 2AAA");

    // R13: abort then the aborting write is data
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h0020, 8'h3C); settle();
    rd_chk(15'h0020, 8'h3C, 8'hFF, 0, "R13 aborting write stored");
    wr(15'h0021, 8'h3D); settle();
    rd_chk(15'h0021, 8'h3D, 8'hFF, 0, "R13 still unprotected");

    // R7 R11: enable; command bytes not stored
    enable_seq(); settle();
    rd_chk(15'h5555, 8'h33, 8'hFF, 0, "R11 command data not stored 5555");
    rd_chk(15'h2AAA, 8'h44, 8'hFF, 0, "R11 command data not stored 2AAA");

    // R8: rejected write still runs a cycle
    wr(15'h0010, 8'h77);
    rd_chk(15'h0010, 8'h11, 8'hBF, 0, "R8 status during dummy cycle");
    rd_chk(15'h0010, 8'h11, 8'hBF, 1, "R8 toggle during dummy cycle");
    settle();
    rd_chk(15'h0010, 8'h11, 8'hFF, 0, "R7 R8 protected write not stored");

    // R9: unlocked page write, then unlock lapses
    enable_seq(); wr(15'h0010, 8'h99); settle();
    rd_chk(15'h0010, 8'h99, 8'hFF, 0, "R9 unlocked write stored");
    wr(15'h0010, 8'h98); settle();
    rd_chk(15'h0010, 8'h99, 8'hFF, 0, "R9 unlock lapses after cycle");

    // R13: aborted sequence while protected
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h0011, 8'h5A); settle();
    rd_chk(15'h0011, 8'h22, 8'hFF, 0, "R13 abort while protected rejected");

    // R12 R3: power and reset cycle with protection on
    pwr_good = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pwr_good = 1'b1;
    @(negedge clk);
    wr(15'h0018, 8'h66);
    rd_chk(15'h0018, 8'h31, 8'hFF, 0, "R3 lockout write dropped");
    rd_chk(15'h0018, 8'h31, 8'hFF, 0, "R3 lockout starts no timer");
    repeat (LOCK + 5) @(negedge clk);
    wr(15'h0019, 8'h55); settle();
    rd_chk(15'h0019, 8'h32, 8'hFF, 0, "R12 protection survives power and reset");

    // R10: disable
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h20); settle();
    wr(15'h0011, 8'h12); settle();
    rd_chk(15'h0011, 8'h12, 8'hFF, 0, "R10 write after disable");
    rd_chk(15'h5555, 8'h33, 8'hFF, 0, "R10 R11 disable data not stored");

    // R12: retain reset clears protection
    enable_seq(); settle();
    retain_rst_n = 1'b0;
    @(negedge clk);
    retain_rst_n = 1'b1;
    @(negedge clk);
    wr(15'h0011, 8'h13); settle();
    rd_chk(15'h0011, 8'h13, 8'hFF, 0, "R12 retain reset clears protection");

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: got %0d unchecked items expected 0", sb_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule